// File: doc/BRIEF.md
# Hot-Plug Controller Register File with Indirect Window

This block holds the byte registers of a hot-plug slot controller. Each byte has its own plain-write mask and its own write-one-to-clear mask, both fixed at elaboration. A direct register port accepts little-endian accesses of one to four bytes. Lanes that land at or past the end of the register file are dropped on writes and read as zero.

A second path reaches the same registers through an 8-byte window in configuration space. Byte 2 of the window selects a register dword. Bytes 4 to 7 hold a snapshot of the dword at select × 4. A window write that touches the data bytes sends the whole 32-bit data field to that dword, and the same masks apply to it. The snapshot is reloaded from the register file one cycle after any window write.

A set port lets the neighbouring hot-plug logic OR event and status bits into a byte. The block emits one-cycle pulses that start the command logic and the interrupt logic.

Top module: `hpc_regfile`

## Requirements
- R1: A byte written through either path takes the new data only in the bits its plain-write mask allows. The mask is 0xFF at byte 0x14, 0x1F at byte 0x15, 0x0F at byte 0x20 and 0x7F at each slot byte 0x24+4·s+3. Every other byte is read-only to writes.
- R2: Writing a 1 to a write-one-to-clear bit clears it, and writing a 0 leaves it unchanged. These bits are bits 0 and 1 of byte 0x22 and bits 0 to 4 of each slot byte 0x24+4·s+2.
- R3: Reset loads byte 0x0C with NUM_SLOTS, byte 0x13 with 0x01, byte 0x20 with 0x0F and each slot byte 0x24+4·s+3 with 0x7F. All other bytes, the window select and the window data reset to zero, and both pulses are low.
- R4: bus_size encodes size−1 bytes, and byte lane i maps to address bus_addr+i. A lane at or past 0x24+4·NUM_SLOTS reads zero and its write is dropped. Lanes past the access size read zero.
- R5: cmd_pulse is high for exactly the cycle after a write, from either path, that changes a lane at byte 0x14 or byte 0x15.
- R6: eval_pulse is high for the cycle after any write from either path that has at least one lane inside the register file. A write with no such lane gives no pulse.
- R7: A set-port request ORs set_bits into the addressed byte after both write paths are applied. A set therefore wins over a same-cycle write-one-to-clear.
- R8: Window reads return the select at byte 2 and the data field at bytes 4 to 7. Window bytes 0, 1 and 3 read zero. Window byte lanes past byte 7 are dropped.
- R9: The window data field reloads from the register dword at select × 4 (zero past the end) in the cycle after any window write. Direct writes leave the field stale until the next window write.
- R10: A window write that touches bytes 4 to 7 forwards the merged 32-bit data field, all four bytes, to address (new select) × 4, applying R1, R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Direct write strobe |
| bus_addr | input | AW | Direct byte address |
| bus_size | input | 2 | Access size minus one |
| bus_wdata | input | 32 | Direct write data, lane 0 in bits 7:0 |
| bus_rdata | output | 32 | Direct read data (combinational) |
| cfg_we | input | 1 | Window write strobe |
| cfg_addr | input | 3 | Byte offset inside the window |
| cfg_size | input | 2 | Window access size minus one |
| cfg_wdata | input | 32 | Window write data |
| cfg_rdata | output | 32 | Window read data (combinational) |
| set_en | input | 1 | Bit-set request from hot-plug logic |
| set_addr | input | AW | Byte address for the set |
| set_bits | input | 8 | Bits to OR into the byte |
| cmd_pulse | output | 1 | Command bytes were written |
| eval_pulse | output | 1 | Interrupt state needs re-evaluation |

## Verification
The assertions assume that bus_we, cfg_we and set_en are low through reset and that no input carries X at a clock edge. The pulse and stability properties rely on this to tie each register change or pulse to a write strobe in the previous cycle. The stimulus changes inputs only on the falling edge and returns every strobe to zero after a single cycle. It also holds all strobes low while reset is asserted.

// File: rtl/hpc_regfile.sv
module hpc_regfile #(
  parameter int NUM_SLOTS = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [1:0]    cfg_size,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [7:0]    set_bits,
  output logic          cmd_pulse,
  output logic          eval_pulse
);
  localparam int SLOT0 = 36;
  localparam int SIZE = SLOT0 + 4 * NUM_SLOTS;
  localparam int AIW = $clog2(SIZE);
  localparam int CMD_LO = 20;
  localparam int CMD_HI = 21;
  localparam int CTRL = 32;
  localparam int CTRL_FLAGS = 34;
  localparam int NSLOT_BYTE = 12;
  localparam int IFC_BYTE = 19;
  localparam int WIN_SEL = 2;
  localparam int WIN_DATA = 4;
  localparam int WIN_LEN = 8;

  function automatic logic [SIZE-1:0][7:0] build_tab(input int kind);
    logic [SIZE-1:0][7:0] t;
    t = '0;
    for (int a = 0; a < SIZE; a++) begin
      int off;
      logic [7:0] v;
      off = a - SLOT0;
      v = 8'h00;
      case (kind)
        0: begin
          if (a == CMD_LO) v = 8'hFF;
          if (a == CMD_HI) v = 8'h1F;
          if (a == CTRL) v = 8'h0F;
          if (a >= SLOT0 && off % 4 == 3) v = 8'h7F;
        end
        1: begin
          if (a == CTRL_FLAGS) v = 8'h03;
          if (a >= SLOT0 && off % 4 == 2) v = 8'h1F;
        end
        default: begin
          if (a == NSLOT_BYTE) v = 8'(NUM_SLOTS);
          if (a == IFC_BYTE) v = 8'h01;
          if (a == CTRL) v = 8'h0F;
          if (a >= SLOT0 && off % 4 == 3) v = 8'h7F;
        end
      endcase
      t[a[AIW-1:0]] = v;
    end
    return t;
  endfunction

  localparam logic [SIZE-1:0][7:0] WM  = build_tab(0);
  localparam logic [SIZE-1:0][7:0] WC  = build_tab(1);
  localparam logic [SIZE-1:0][7:0] RST = build_tab(2);

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] wm,
                                       input logic [7:0] wc, input logic [7:0] d);
    return ((old & ~wm) | (d & wm)) & ~(d & wc);
  endfunction

  logic [SIZE-1:0][7:0] mem, mem_d;
  logic [7:0]  win_sel, sel_n;
  logic [31:0] win_data, data_n, sel_dword;
  logic        refresh, touch, dat_touch, cmd_hit, any_hit;

  always_comb begin
    sel_n = win_sel;
    data_n = win_data;
    touch = 1'b0;
    dat_touch = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int c;
      c = int'(cfg_addr) + i;
      if (cfg_we && i <= int'(cfg_size) && c < WIN_LEN) begin
        touch = 1'b1;
        if (c == WIN_SEL) sel_n = cfg_wdata[8*i +: 8];
        if (c >= WIN_DATA) begin
          data_n[8*(c-WIN_DATA) +: 8] = cfg_wdata[8*i +: 8];
          dat_touch = 1'b1;
        end
      end
    end
  end

  always_comb begin
    mem_d = mem;
    cmd_hit = 1'b0;
    any_hit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int a;
      a = int'(bus_addr) + i;
      if (bus_we && i <= int'(bus_size) && a < SIZE) begin
        mem_d[AIW'(a)] = merge(mem_d[AIW'(a)], WM[AIW'(a)], WC[AIW'(a)], bus_wdata[8*i +: 8]);
        any_hit = 1'b1;
        if (a == CMD_LO || a == CMD_HI) cmd_hit = 1'b1;
      end
    end
    for (int i = 0; i < 4; i++) begin
      int a;
      a = int'(sel_n) * 4 + i;
      if (dat_touch && a < SIZE) begin
        mem_d[AIW'(a)] = merge(mem_d[AIW'(a)], WM[AIW'(a)], WC[AIW'(a)], data_n[8*i +: 8]);
        any_hit = 1'b1;
        if (a == CMD_LO || a == CMD_HI) cmd_hit = 1'b1;
      end
    end
    if (set_en && int'(set_addr) < SIZE)
      mem_d[AIW'(set_addr)] = mem_d[AIW'(set_addr)] | set_bits;
  end

  always_comb begin
    sel_dword = '0;
    for (int j = 0; j < 4; j++) begin
      int a;
      a = int'(win_sel) * 4 + j;
      if (a < SIZE) sel_dword[8*j +: 8] = mem[AIW'(a)];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      int a;
      a = int'(bus_addr) + i;
      if (i <= int'(bus_size) && a < SIZE) bus_rdata[8*i +: 8] = mem[AIW'(a)];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      int c;
      c = int'(cfg_addr) + i;
      if (i <= int'(cfg_size) && c < WIN_LEN) begin
        if (c == WIN_SEL) cfg_rdata[8*i +: 8] = win_sel;
        if (c >= WIN_DATA) cfg_rdata[8*i +: 8] = win_data[8*(c-WIN_DATA) +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem        <= RST;
      win_sel    <= '0;
      win_data   <= '0;
      refresh    <= 1'b1;
      cmd_pulse  <= 1'b0;
      eval_pulse <= 1'b0;
    end else begin
      mem        <= mem_d;
      win_sel    <= sel_n;
      refresh    <= touch;
      win_data   <= refresh ? sel_dword : data_n;
      cmd_pulse  <= cmd_hit;
      eval_pulse <= any_hit;
    end
  end
endmodule

// File: rtl/hpc_regfile_checks.sv
module hpc_regfile_checks #(
  parameter int SIZE = 52,
  parameter int AW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic                 cfg_we,
  input logic                 set_en,
  input logic [AW-1:0]        bus_addr,
  input logic [31:0]          bus_rdata,
  input logic                 cmd_pulse,
  input logic                 eval_pulse,
  input logic [7:0]           win_sel,
  input logic [SIZE-1:0][7:0] mem
);
  AST_CMD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |-> $past(bus_we || cfg_we)); // R5
  AST_CMD_WITH_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |-> eval_pulse); // R5
  AST_EVAL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_pulse |-> $past(bus_we || cfg_we)); // R6
  AST_IDLE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we || cfg_we || set_en) |=> $stable(mem)); // R1
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(win_sel)); // R8
  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) >= SIZE) |-> bus_rdata == 32'h0); // R4
endmodule

bind hpc_regfile hpc_regfile_checks #(.SIZE(SIZE), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .cfg_we(cfg_we), .set_en(set_en),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cmd_pulse(cmd_pulse),
  .eval_pulse(eval_pulse), .win_sel(win_sel), .mem(mem));

// File: tb/hpc_regfile_test.sv
module hpc_regfile_test;
  localparam int CLK_P = 10;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, cfg_we = 0, set_en = 0;
  logic [AW-1:0] bus_addr = '0, set_addr = '0;
  logic [1:0] bus_size = '0, cfg_size = '0;
  logic [31:0] bus_wdata = '0, cfg_wdata = '0, bus_rdata, cfg_rdata;
  logic [2:0] cfg_addr = '0;
  logic [7:0] set_bits = '0;
  logic cmd_pulse, eval_pulse;
  int checks = 0, errors = 0;
  logic [31:0] rd;

  hpc_regfile #(.NUM_SLOTS(4), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .set_en(set_en),
    .set_addr(set_addr), .set_bits(set_bits), .cmd_pulse(cmd_pulse), .eval_pulse(eval_pulse));

  always #(CLK_P/2) clk = ~clk;

  // fields: addr, size, write data, expected read-back
  localparam logic [79:0] VEC [8] = '{
    {8'h14, 8'd1, 32'h0000FFFF, 32'h00001FFF},
    {8'h0C, 8'd0, 32'h00000055, 32'h00000004},
    {8'h20, 8'd3, 32'hFFFFFFF0, 32'h00000000},
    {8'h20, 8'd0, 32'h00000005, 32'h00000005},
    {8'h27, 8'd0, 32'h000000FF, 32'h0000007F},
    {8'h24, 8'd3, 32'hFFFFFFFF, 32'h7F000000},
    {8'h34, 8'd3, 32'h12345678, 32'h00000000},
    {8'h32, 8'd3, 32'h55555555, 32'h00005500}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bread(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
    bus_addr = a; bus_size = s;
    #1 d = bus_rdata;
  endtask

  task automatic cwrite(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_size = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cread(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
    cfg_addr = a; cfg_size = s;
    #1 d = cfg_rdata;
  endtask

  task automatic hset(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    set_en = 1; set_addr = a; set_bits = b;
    @(negedge clk);
    set_en = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    check("R3 pulses", {30'd0, cmd_pulse, eval_pulse}, 32'h0);
    bread(8'h0C, 0, rd); check("R3 slot count", rd, 32'h04);
    bread(8'h13, 0, rd); check("R3 ifc byte", rd, 32'h01);
    bread(8'h20, 3, rd); check("R3 control", rd, 32'h0000000F);
    bread(8'h27, 0, rd); check("R3 event mask", rd, 32'h7F);
    cread(0, 3, rd); check("R3 window low", rd, 32'h0);
    cread(4, 3, rd); check("R3 window data", rd, 32'h0);

    // R1 R4 mask table
    foreach (VEC[k]) begin
      bwrite(VEC[k][79:72], VEC[k][65:64], VEC[k][63:32]);
      bread(VEC[k][79:72], VEC[k][65:64], rd);
      check("R1/R4 table", rd, VEC[k][31:0]);
    end

    // R4 range and lanes
    bread(8'h40, 3, rd); check("R4 far read", rd, 32'h0);
    bread(8'h33, 1, rd); check("R4 crossing read", rd, 32'h00000055);
    bwrite(8'h34, 0, 32'hFF);
    check("R6 no eval out of range", {31'd0, eval_pulse}, 32'h0);

    // R5 R6 pulses
    bwrite(8'h13, 1, 32'h0000);
    check("R5 cmd on 0x14", {31'd0, cmd_pulse}, 32'h1);
    check("R6 eval on write", {31'd0, eval_pulse}, 32'h1);
    @(negedge clk);
    check("R5 single cycle", {31'd0, cmd_pulse}, 32'h0);
    bwrite(8'h12, 0, 32'h00);
    check("R5 no cmd at 0x12", {31'd0, cmd_pulse}, 32'h0);
    check("R6 eval at 0x12", {31'd0, eval_pulse}, 32'h1);
    bwrite(8'h15, 0, 32'h03);
    check("R5 cmd on 0x15", {31'd0, cmd_pulse}, 32'h1);
    bwrite(8'h16, 1, 32'hFFFF);
    check("R5 no cmd at 0x16", {31'd0, cmd_pulse}, 32'h0);

    // R2 write-one-to-clear
    hset(8'h26, 8'hFF);
    bread(8'h26, 0, rd); check("R7 set bits", rd, 32'hFF);
    bwrite(8'h26, 0, 32'h05);
    bread(8'h26, 0, rd); check("R2 clear ones", rd, 32'hFA);
    bwrite(8'h26, 0, 32'h00);
    bread(8'h26, 0, rd); check("R2 zeros keep", rd, 32'hFA);
    hset(8'h22, 8'h03);
    bwrite(8'h20, 3, 32'h00010000);
    bread(8'h20, 3, rd); check("R2 control flags", rd, 32'h00020000);

    // R7 set wins over same-cycle clear
    @(negedge clk);
    set_en = 1; set_addr = 8'h26; set_bits = 8'h01;
    bus_we = 1; bus_addr = 8'h26; bus_size = 0; bus_wdata = 32'h01;
    @(negedge clk);
    set_en = 0; bus_we = 0;
    bread(8'h26, 0, rd); check("R7 set beats clear", rd, 32'hFB);

    // R8 R9 window
    cwrite(2, 0, 32'h09);
    check("R6 no eval select only", {31'd0, eval_pulse}, 32'h0);
    @(negedge clk);
    cread(0, 3, rd); check("R8 select byte", rd, 32'h00090000);
    cread(4, 3, rd); check("R9 snapshot", rd, 32'h7FFB0000);
    cread(6, 3, rd); check("R8 lanes past 7", rd, 32'h00007FFB);
    bwrite(8'h27, 0, 32'h11);
    cread(4, 3, rd); check("R9 stale", rd, 32'h7FFB0000);
    cwrite(2, 0, 32'h09);
    @(negedge clk);
    cread(4, 3, rd); check("R9 refreshed", rd, 32'h11FB0000);

    // R10 forwarding
    cwrite(4, 3, 32'h00FF0000);
    check("R6 eval on forward", {31'd0, eval_pulse}, 32'h1);
    @(negedge clk);
    cread(4, 3, rd); check("R10 window after fwd", rd, 32'h00E00000);
    bread(8'h24, 3, rd); check("R10 regs after fwd", rd, 32'h00E00000);
    cwrite(7, 0, 32'h33);
    @(negedge clk);
    bread(8'h24, 3, rd); check("R10 whole dword", rd, 32'h33E00000);
    cwrite(2, 0, 32'h05);
    @(negedge clk);
    cwrite(4, 0, 32'h12);
    check("R5 cmd via window", {31'd0, cmd_pulse}, 32'h1);
    bread(8'h14, 1, rd); check("R10 fwd to cmd", rd, 32'h0312);
    cwrite(2, 0, 32'h40);
    @(negedge clk);
    cread(4, 3, rd); check("R9 select past end", rd, 32'h0);
    cwrite(4, 3, 32'hFFFFFFFF);
    check("R10 fwd past end dropped", {31'd0, eval_pulse}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule